// File: doc/BRIEF.md
# Toggle-Triggered Falling-Edge Word Memory

This block wraps a single-port word memory for a datapath that runs on the rising clock edge. The datapath never reaches into the storage array. To ask for an access it presents a byte address, a write flag and write data, and then inverts one request line. The block keeps a private copy of that line.

On the next falling edge the block sees that the line and its copy disagree. It then carries out exactly one store or load and copies the line, which makes it idle again. A load therefore returns its word half a cycle after the request, before the datapath's next rising edge. Back-to-back datapath states can each issue an access with no disable state between them.

Words are 32 bits. Byte addresses are always word aligned, and the word index is the byte address divided by four. All reads and writes of the array sit in one clocked process, so that synthesis infers a RAM.

Top module: `tgl_ram`

## Requirements
- R1: Every access is carried out at a falling edge of clk_i. After a load, rdata_o shows the addressed word once the falling edge that follows the request has passed, before the next rising edge. Up to that falling edge, rdata_o keeps its earlier value.
- R2: An access takes place only at a falling edge where req_tgl_i differs from the internal request copy. While req_tgl_i is held steady, changes on wr_i, addr_i and wdata_i write nothing.
- R3: When an access takes place, the internal copy takes the value of req_tgl_i, so each inversion of req_tgl_i gives exactly one access.
- R4: Inversions of req_tgl_i in adjacent clock cycles each give one access, with no idle cycle needed between them.
- R5: The word index is addr_i divided by four, and addr_i is always a multiple of four. Each index from 0 to DEPTH-1 selects its own 32-bit word.
- R6: In an access with wr_i = 1, wdata_i is stored at the word index. In an access with wr_i = 0, the word at the index is loaded into rdata_o. A word stored in one cycle reads back in the next cycle.
- R7: rdata_o changes only through a load. It holds its value across stores and across cycles with no access.
- R8: rst_ni low clears the internal copy to 0 asynchronously and blocks any access while it is low. After release, with req_tgl_i at 0, the block does not access memory until req_tgl_i is first inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the datapath uses the rising edge, the memory the falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_tgl_i | input | 1 | Request line; inverting it asks for one access |
| wr_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address, word aligned |
| wdata_i | input | 32 | Data to store |
| rdata_o | output | 32 | Last word loaded |

## Verification
Two functions can fall in the same cycle. The first is the self-disable after one access. The second is a new request in the very next datapath state: an inversion of the request line in the cycle right after an access, so that the copy update and the fresh mismatch meet at one falling edge. The bench provokes this with full-depth sweeps of back-to-back stores and loads, and with store-then-load pairs in adjacent cycles. It judges each word read back against an arithmetic pattern. It then holds the request line steady while the address and data keep changing and write stays high, and shows through later loads that no extra write took place.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned DEF_DEPTH = 64;

  function automatic int unsigned idx_width(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned off_width(int unsigned word_w);
    return (word_w > BYTE_W) ? $clog2(word_w / BYTE_W) : 0;
  endfunction
endpackage

// File: rtl/tgl_ram_req.sv
module tgl_ram_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_tgl_i,
  output logic fire_o,
  output logic copy_o
);
  logic copy_q;

  // mismatch between request line and copy arms one access
  assign fire_o = rst_ni && (req_tgl_i != copy_q);
  assign copy_o = copy_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     copy_q <= 1'b0;
    else if (fire_o) copy_q <= req_tgl_i;
  end
endmodule

// File: rtl/tgl_ram_store.sv
module tgl_ram_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // sole access point of the array
  always_ff @(negedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[idx_i] <= wdata_i;
      else      rdata_o    <= mem[idx_i];
    end
  end
endmodule

// File: rtl/tgl_ram.sv
module tgl_ram #(
  parameter int unsigned DEPTH = tgl_ram_pkg::DEF_DEPTH
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_tgl_i,
  input  logic        wr_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int unsigned DATA_W = tgl_ram_pkg::WORD_W;
  localparam int unsigned OFF_W  = tgl_ram_pkg::off_width(DATA_W);
  localparam int unsigned IDX_W  = tgl_ram_pkg::idx_width(DEPTH);

  logic             acc_fire;
  logic             req_copy;
  logic [IDX_W-1:0] word_idx;

  assign word_idx = addr_i[IDX_W+OFF_W-1:OFF_W];

  tgl_ram_req u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl_i),
    .fire_o    (acc_fire),
    .copy_o    (req_copy)
  );

  tgl_ram_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk_i   (clk_i),
    .en_i    (acc_fire),
    .we_i    (wr_i),
    .idx_i   (word_idx),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/tgl_ram_chk.sv
module tgl_ram_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned OFF_W = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_tgl_i,
  input logic [31:0] addr_i,
  input logic [31:0] rdata_o,
  input logic        req_copy,
  input logic        acc_fire
);
  // R3
  copy_follow_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    acc_fire |=> (req_copy == $past(req_tgl_i)));

  // R2
  single_shot_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    acc_fire |=> !(acc_fire && $stable(req_tgl_i)));

  // R5
  addr_align_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    acc_fire |-> (addr_i[OFF_W-1:0] == '0 && (addr_i >> OFF_W) < DEPTH));

  // R8
  reset_idle_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_copy == 1'b0));

  // R1
  always @(rdata_o) begin
    if (rst_ni) begin
      fall_edge_chk: assert (!clk_i);
    end
  end
endmodule

bind tgl_ram tgl_ram_chk #(
  .DEPTH (DEPTH),
  .OFF_W (OFF_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_tgl_i (req_tgl_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .req_copy  (req_copy),
  .acc_fire  (acc_fire)
);

// File: tb/sim_tgl_ram.sv
module sim_tgl_ram;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tgl = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] q;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tgl_ram #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_tgl_i(tgl), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] pat(int i, logic [31:0] salt);
    return (32'(i) * 32'h9E37_79B1) ^ salt;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(int w, logic [31:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = 32'(w * 4); wdata = d; tgl = ~tgl;
    @(negedge clk); #1;
  endtask

  task automatic load(int w, output logic [31:0] r);
    @(posedge clk); #1;
    wr = 1'b0; addr = 32'(w * 4); tgl = ~tgl;
    @(negedge clk); #1;
    r = rdata;
  endtask

  task automatic idle(logic w, int wd, logic [31:0] d);
    @(posedge clk); #1;
    wr = w; addr = 32'(wd * 4); wdata = d;
    @(negedge clk); #1;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R4 R6: back-to-back store sweep, then back-to-back load sweep
    for (int i = 0; i < DEPTH; i++) store(i, pat(i, 32'h0F0F_1234));
    for (int i = 0; i < DEPTH; i++) begin
      load(i, q);
      chk($sformatf("R5 R4 word %0d", i), q, pat(i, 32'h0F0F_1234));
    end

    // R1: old value until falling edge, new value right after it
    load(2, q);
    @(posedge clk); #1;
    wr = 1'b0; addr = 32'(3 * 4); tgl = ~tgl;
    #4 chk("R1 before falling edge", rdata, pat(2, 32'h0F0F_1234));
    @(negedge clk); #1;
    chk("R1 after falling edge", rdata, pat(3, 32'h0F0F_1234));

    // R6 R4: store then load in adjacent cycles, descending
    for (int i = DEPTH - 1; i >= 0; i--) begin
      store(i, pat(i, 32'hA5C3_0000));
      load(i, q);
      chk($sformatf("R6 word %0d", i), q, pat(i, 32'hA5C3_0000));
    end

    // R2: toggle held, writes requested at other words
    store(5, 32'hDEAD_0005);
    idle(1'b1, 5, 32'h1111_1111);
    idle(1'b1, 6, 32'h2222_2222);
    idle(1'b1, 6, 32'h3333_3333);
    load(5, q);
    chk("R2 held toggle word 5", q, 32'hDEAD_0005);
    load(6, q);
    chk("R2 held toggle word 6", q, pat(6, 32'hA5C3_0000));

    // R3: one inversion, one write, even with data changing
    @(posedge clk); #1;
    wr = 1'b1; addr = 32'(7 * 4); wdata = 32'hBEEF_0007; tgl = ~tgl;
    @(posedge clk); #1 wdata = 32'h4444_4444;
    @(posedge clk); #1 wdata = 32'h5555_5555;
    @(negedge clk); #1;
    load(7, q);
    chk("R3 single write word 7", q, 32'hBEEF_0007);

    // R7: rdata holds across stores and idle cycles
    load(10, q);
    chk("R7 load word 10", q, pat(10, 32'hA5C3_0000));
    store(11, 32'hC0DE_0011);
    chk("R7 hold across store", rdata, pat(10, 32'hA5C3_0000));
    idle(1'b0, 12, 32'h0);
    idle(1'b1, 13, 32'h6666_6666);
    chk("R7 hold across idle", rdata, pat(10, 32'hA5C3_0000));
    load(11, q);
    chk("R7 stored word 11", q, 32'hC0DE_0011);
    load(13, q);
    chk("R7 idle wrote nothing word 13", q, pat(13, 32'hA5C3_0000));

    // R8: reset clears copy, no access with toggle low afterwards
    if (!tgl) load(1, q);
    @(posedge clk); #1;
    rst_n = 1'b0; tgl = 1'b0; wr = 1'b1; addr = 32'h0; wdata = 32'h7777_7777;
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(1'b1, 0, 32'h8888_8888);
    idle(1'b1, 0, 32'h9999_9999);
    load(0, q);
    chk("R8 no access after reset", q, pat(0, 32'hA5C3_0000));
    store(0, 32'h0BAD_F00D);
    load(0, q);
    chk("R8 first toggle after reset", q, 32'h0BAD_F00D);

    done = 1;
    report();
  end
endmodule